// File: doc/BRIEF.md
# Multicart Mapper Configuration Register File

This block holds the configuration state of a bank controller for an 8-bit console cartridge that carries several games, each built for a different simple discrete mapper. The CPU picks a register by writing an index into a selector window. It then writes the register's new contents into a value window. Four registers exist: a CHR bank, an inner PRG bank, a mode word and an outer PRG bank. They form a user group, which a game changes while it runs, and a supervisor group, which a menu program sets once for each game.

The block drives the two CHR RAM upper address lines straight from the CHR bank register. It drives the nametable RAM select line from the mirroring mode and the PPU address lines A11 and A10. It exports the mode fields, the inner bank and the outer bank to a separate PRG address generator. In a one-screen mirroring mode, writes to either user register also update the low bit of the mirroring mode. This lets a game written for a one-screen-switching board run unchanged.

Registers update on the falling edge of the CPU phase-2 clock and have no reset. A console reset leaves every setting as it was.

Top module: `mcr_cfg_regfile`

## Requirements
- R1: A CPU write (R/W low) with address bits A15-A12 equal to 0101 latches the selector from the data bus. Data bit 7 picks the group (0 user, 1 supervisor) and data bit 0 picks the register in the group. All other data bits are ignored.
- R2: A CPU write with A15 high stores the data into the selected register. The encoding is {group,index}: 00 CHR bank, 01 inner bank, 10 mode, 11 outer bank.
- R3: The CHR bank register keeps data bits 1-0 and drives `chr_bank` directly.
- R4: The inner bank register keeps data bits 3-0 and drives `inner_bank`.
- R5: The mode register keeps data bits 5-0. Bits 1-0 drive `mirror_mode`, bits 3-2 drive `prg_mode` and bits 5-4 drive `outer_size`.
- R6: The outer bank register keeps the low OUTER_W data bits (6 by default) and drives `outer_bank`.
- R7: `ciram_a10` is 0 for mirroring mode 0 and 1 for mode 1. It follows `ppu_a10` for mode 2 and `ppu_a11` for mode 3.
- R8: In mirroring mode 0 or 1, a write to the CHR bank or inner bank register also copies data bit 4 into mirroring mode bit 0.
- R9: In mirroring mode 2 or 3, data bit 4 of a CHR bank or inner bank write leaves the mirroring mode unchanged.
- R10: Cycles with R/W high, and writes where A15 is low and A15-A12 is not 0101, change no register.
- R11: There is no reset. Settings persist across any number of cycles without a qualifying write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m2 | input | 1 | CPU phase-2 clock; registers commit on its falling edge |
| cpu_rw | input | 1 | CPU read/write, low for a write |
| cpu_addr_hi | input | 4 | CPU address bits A15-A12 |
| cpu_data | input | 8 | CPU data bus |
| ppu_a11 | input | 1 | PPU address bit 11 |
| ppu_a10 | input | 1 | PPU address bit 10 |
| chr_bank | output | 2 | CHR RAM address bits 14-13 |
| ciram_a10 | output | 1 | Nametable RAM bank select |
| mirror_mode | output | 2 | Current mirroring mode |
| prg_mode | output | 2 | PRG bank mode field |
| outer_size | output | 2 | PRG outer bank size field |
| inner_bank | output | 4 | Inner PRG bank |
| outer_bank | output | 6 | Outer PRG bank (OUTER_W bits) |

## Verification
The checker assumes that the CPU address, data and R/W lines are steady at every falling edge of `m2`. It also assumes that the PPU lines are steady at every rising edge, where the nametable select is sampled. The bench changes every input shortly after a rising edge, so each value has settled before the commit edge and holds until the next sample edge. Because there is no reset, the checker disarms itself until the first falling edge. The bench loads all four registers before it compares anything.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

   typedef enum logic [1:0] {
      MIR_ONE_LO = 2'd0,
      MIR_ONE_HI = 2'd1,
      MIR_VERT   = 2'd2,
      MIR_HORIZ  = 2'd3
   } mirror_e;

   typedef enum logic [1:0] {
      REG_CHR   = 2'b00,
      REG_INNER = 2'b01,
      REG_MODE  = 2'b10,
      REG_OUTER = 2'b11
   } reg_id_e;

   localparam int MODE_W        = 6;
   localparam int MIRR_DATA_BIT = 4;
   localparam int SEL_GROUP_BIT = 7;
   localparam int SEL_INDEX_BIT = 0;

   function automatic logic is_one_screen(input mirror_e m);
      return (m == MIR_ONE_LO) || (m == MIR_ONE_HI);
   endfunction

endpackage

// File: rtl/mcr_bus_decode.sv
module mcr_bus_decode #(
   parameter int          PAGE_W   = 4,
   parameter logic [3:0]  SEL_PAGE = 4'h5
) (
   input  logic              cpu_rw,
   input  logic [PAGE_W-1:0] cpu_addr_hi,
   output logic              sel_we,
   output logic              val_we
);
   localparam int TOP_BIT = PAGE_W - 1;

   always_comb begin
      sel_we = !cpu_rw && (cpu_addr_hi == SEL_PAGE[PAGE_W-1:0]);
      val_we = !cpu_rw && cpu_addr_hi[TOP_BIT];
   end
endmodule

// File: rtl/mcr_cfg_store.sv
module mcr_cfg_store
   import mcr_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CHR_W   = 2,
   parameter int INNER_W = 4,
   parameter int OUTER_W = 6
) (
   input  logic               m2,
   input  logic               sel_we,
   input  logic               val_we,
   input  logic [DATA_W-1:0]  cpu_data,
   output logic               sel_sup,
   output logic               sel_idx,
   output logic [CHR_W-1:0]   chr_q,
   output logic [INNER_W-1:0] inner_q,
   output mirror_e            mirror_q,
   output logic [1:0]         prg_q,
   output logic [1:0]         size_q,
   output logic [OUTER_W-1:0] outer_q
);
   reg_id_e target;
   logic    user_hit;
   logic    follow_d4;
   logic    unused_data;

   assign target    = reg_id_e'({sel_sup, sel_idx});
   assign user_hit  = val_we && (target == REG_CHR || target == REG_INNER);
   assign follow_d4 = user_hit && is_one_screen(mirror_q);
   assign unused_data = ^cpu_data;

   // selector
   always_ff @(negedge m2) begin
      if (sel_we) begin
         sel_sup <= cpu_data[SEL_GROUP_BIT];
         sel_idx <= cpu_data[SEL_INDEX_BIT];
      end
   end

   // user group
   always_ff @(negedge m2) begin
      if (val_we && target == REG_CHR)
         chr_q <= cpu_data[CHR_W-1:0];
      if (val_we && target == REG_INNER)
         inner_q <= cpu_data[INNER_W-1:0];
   end

   // supervisor group
   always_ff @(negedge m2) begin
      if (val_we && target == REG_MODE) begin
         mirror_q <= mirror_e'(cpu_data[1:0]);
         prg_q    <= cpu_data[3:2];
         size_q   <= cpu_data[5:4];
      end else if (follow_d4) begin
         mirror_q <= mirror_e'({1'b0, cpu_data[MIRR_DATA_BIT]});
      end
      if (val_we && target == REG_OUTER)
         outer_q <= cpu_data[OUTER_W-1:0];
   end
endmodule

// File: rtl/mcr_nt_select.sv
module mcr_nt_select
   import mcr_pkg::*;
(
   input  mirror_e mirror,
   input  logic    ppu_a11,
   input  logic    ppu_a10,
   output logic    ciram_a10
);
   always_comb begin
      unique case (mirror)
         MIR_ONE_LO: ciram_a10 = 1'b0;
         MIR_ONE_HI: ciram_a10 = 1'b1;
         MIR_VERT:   ciram_a10 = ppu_a10;
         MIR_HORIZ:  ciram_a10 = ppu_a11;
         default:    ciram_a10 = 1'b0;
      endcase
   end
endmodule

// File: rtl/mcr_cfg_regfile.sv
module mcr_cfg_regfile
   import mcr_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int PAGE_W  = 4,
   parameter int CHR_W   = 2,
   parameter int INNER_W = 4,
   parameter int OUTER_W = 6
) (
   input  logic               m2,
   input  logic               cpu_rw,
   input  logic [PAGE_W-1:0]  cpu_addr_hi,
   input  logic [DATA_W-1:0]  cpu_data,
   input  logic               ppu_a11,
   input  logic               ppu_a10,
   output logic [CHR_W-1:0]   chr_bank,
   output logic               ciram_a10,
   output logic [1:0]         mirror_mode,
   output logic [1:0]         prg_mode,
   output logic [1:0]         outer_size,
   output logic [INNER_W-1:0] inner_bank,
   output logic [OUTER_W-1:0] outer_bank
);
   if (DATA_W != 8) begin : g_bad_data
      $error("mcr_cfg_regfile: DATA_W must be 8");
   end
   if (PAGE_W != 4) begin : g_bad_page
      $error("mcr_cfg_regfile: PAGE_W must be 4");
   end
   if (OUTER_W < 4 || OUTER_W > DATA_W) begin : g_bad_outer
      $error("mcr_cfg_regfile: OUTER_W out of range");
   end
   if (INNER_W > MIRR_DATA_BIT || CHR_W > MIRR_DATA_BIT) begin : g_bad_user
      $error("mcr_cfg_regfile: user field overlaps mirroring bit");
   end

   logic    sel_we_w, val_we_w;
   logic    sel_sup_w, sel_idx_w;
   mirror_e mirror_w;

   mcr_bus_decode #(.PAGE_W(PAGE_W), .SEL_PAGE(4'h5)) u_dec (
      .cpu_rw      (cpu_rw),
      .cpu_addr_hi (cpu_addr_hi),
      .sel_we      (sel_we_w),
      .val_we      (val_we_w)
   );

   mcr_cfg_store #(
      .DATA_W(DATA_W), .CHR_W(CHR_W), .INNER_W(INNER_W), .OUTER_W(OUTER_W)
   ) u_store (
      .m2       (m2),
      .sel_we   (sel_we_w),
      .val_we   (val_we_w),
      .cpu_data (cpu_data),
      .sel_sup  (sel_sup_w),
      .sel_idx  (sel_idx_w),
      .chr_q    (chr_bank),
      .inner_q  (inner_bank),
      .mirror_q (mirror_w),
      .prg_q    (prg_mode),
      .size_q   (outer_size),
      .outer_q  (outer_bank)
   );

   mcr_nt_select u_nt (
      .mirror    (mirror_w),
      .ppu_a11   (ppu_a11),
      .ppu_a10   (ppu_a10),
      .ciram_a10 (ciram_a10)
   );

   assign mirror_mode = mirror_w;
endmodule

// File: rtl/mcr_cfg_regfile_chk.sv
module mcr_cfg_regfile_chk #(
   parameter int CHR_W   = 2,
   parameter int INNER_W = 4,
   parameter int OUTER_W = 6
) (
   input logic               m2,
   input logic               cpu_rw,
   input logic [3:0]         cpu_addr_hi,
   input logic [7:0]         cpu_data,
   input logic               ppu_a11,
   input logic               ppu_a10,
   input logic [CHR_W-1:0]   chr_bank,
   input logic               ciram_a10,
   input logic [1:0]         mirror_mode,
   input logic [1:0]         prg_mode,
   input logic [1:0]         outer_size,
   input logic [INNER_W-1:0] inner_bank,
   input logic [OUTER_W-1:0] outer_bank,
   input logic               sel_sup,
   input logic               sel_idx
);
   logic armed = 1'b0;
   always_ff @(negedge m2) armed <= 1'b1;

   logic wr_sel, wr_val, hit_chr, hit_inner, hit_mode, hit_outer, hit_user;
   assign wr_sel    = !cpu_rw && cpu_addr_hi == 4'b0101;
   assign wr_val    = !cpu_rw && cpu_addr_hi[3];
   assign hit_chr   = wr_val && !sel_sup && !sel_idx;
   assign hit_inner = wr_val && !sel_sup &&  sel_idx;
   assign hit_mode  = wr_val &&  sel_sup && !sel_idx;
   assign hit_outer = wr_val &&  sel_sup &&  sel_idx;
   assign hit_user  = hit_chr || hit_inner;

   p_sel_load_r1: assert property (@(negedge m2) disable iff (!armed)
      wr_sel |=> (sel_sup == $past(cpu_data[7]) && sel_idx == $past(cpu_data[0])));

   p_chr_load_r3: assert property (@(negedge m2) disable iff (!armed)
      hit_chr |=> chr_bank == $past(cpu_data[CHR_W-1:0]));

   p_inner_load_r4: assert property (@(negedge m2) disable iff (!armed)
      hit_inner |=> inner_bank == $past(cpu_data[INNER_W-1:0]));

   p_mode_load_r5: assert property (@(negedge m2) disable iff (!armed)
      hit_mode |=> {outer_size, prg_mode, mirror_mode} == $past(cpu_data[5:0]));

   p_outer_load_r6: assert property (@(negedge m2) disable iff (!armed)
      hit_outer |=> outer_bank == $past(cpu_data[OUTER_W-1:0]));

   p_d4_copy_r8: assert property (@(negedge m2) disable iff (!armed)
      (hit_user && !mirror_mode[1]) |=> mirror_mode == {1'b0, $past(cpu_data[4])});

   p_d4_block_r9: assert property (@(negedge m2) disable iff (!armed)
      (hit_user && mirror_mode[1]) |=> $stable(mirror_mode));

   p_idle_hold_r10: assert property (@(negedge m2) disable iff (!armed)
      (!wr_sel && !wr_val) |=> $stable({sel_sup, sel_idx, chr_bank, inner_bank,
                                        mirror_mode, prg_mode, outer_size, outer_bank}));

   p_nt_lo_r7: assert property (@(posedge m2) disable iff (!armed)
      mirror_mode == 2'd0 |-> ciram_a10 == 1'b0);
   p_nt_hi_r7: assert property (@(posedge m2) disable iff (!armed)
      mirror_mode == 2'd1 |-> ciram_a10 == 1'b1);
   p_nt_vert_r7: assert property (@(posedge m2) disable iff (!armed)
      mirror_mode == 2'd2 |-> ciram_a10 == ppu_a10);
   p_nt_horiz_r7: assert property (@(posedge m2) disable iff (!armed)
      mirror_mode == 2'd3 |-> ciram_a10 == ppu_a11);
endmodule

bind mcr_cfg_regfile mcr_cfg_regfile_chk #(
   .CHR_W(CHR_W), .INNER_W(INNER_W), .OUTER_W(OUTER_W)
) u_chk (
   .m2          (m2),
   .cpu_rw      (cpu_rw),
   .cpu_addr_hi (cpu_addr_hi),
   .cpu_data    (cpu_data),
   .ppu_a11     (ppu_a11),
   .ppu_a10     (ppu_a10),
   .chr_bank    (chr_bank),
   .ciram_a10   (ciram_a10),
   .mirror_mode (mirror_mode),
   .prg_mode    (prg_mode),
   .outer_size  (outer_size),
   .inner_bank  (inner_bank),
   .outer_bank  (outer_bank),
   .sel_sup     (sel_sup_w),
   .sel_idx     (sel_idx_w)
);

// File: tb/sim_mcr_cfg_regfile.sv
module sim_mcr_cfg_regfile;
   logic       m2 = 1'b0;
   logic       cpu_rw = 1'b1;
   logic [3:0] cpu_addr_hi = 4'h0;
   logic [7:0] cpu_data = 8'h00;
   logic       ppu_a11 = 1'b0, ppu_a10 = 1'b0;
   logic [1:0] chr_bank, mirror_mode, prg_mode, outer_size;
   logic       ciram_a10;
   logic [3:0] inner_bank;
   logic [5:0] outer_bank;

   mcr_cfg_regfile u0 (
      .m2(m2), .cpu_rw(cpu_rw), .cpu_addr_hi(cpu_addr_hi), .cpu_data(cpu_data),
      .ppu_a11(ppu_a11), .ppu_a10(ppu_a10), .chr_bank(chr_bank),
      .ciram_a10(ciram_a10), .mirror_mode(mirror_mode), .prg_mode(prg_mode),
      .outer_size(outer_size), .inner_bank(inner_bank), .outer_bank(outer_bank)
   );

   always #5 m2 = ~m2;

   int n_chk = 0, n_bad = 0;
   logic [18:0] q_exp[$];
   string       q_tag[$];

   // reference model, from the requirements
   logic       m_sup = 0, m_idx = 0;
   logic [1:0] m_chr = 0, m_mir = 0, m_prg = 0, m_size = 0;
   logic [3:0] m_inner = 0;
   logic [5:0] m_outer = 0;

   function automatic logic [18:0] exp_vec();
      logic nt;
      case (m_mir)
         2'd0: nt = 1'b0;
         2'd1: nt = 1'b1;
         2'd2: nt = ppu_a10;
         default: nt = ppu_a11;
      endcase
      return {m_chr, nt, m_mir, m_prg, m_size, m_inner, m_outer};
   endfunction

   task automatic op(input logic rw, input logic [3:0] hi, input logic [7:0] d,
                     input logic a11, input logic a10, input string tag, input bit push);
      @(posedge m2); #1;
      cpu_rw = rw; cpu_addr_hi = hi; cpu_data = d; ppu_a11 = a11; ppu_a10 = a10;
      if (!rw && hi == 4'b0101) begin
         m_sup = d[7]; m_idx = d[0];
      end
      if (!rw && hi[3]) begin
         case ({m_sup, m_idx})
            2'b00: begin m_chr = d[1:0];   if (!m_mir[1]) m_mir = {1'b0, d[4]}; end
            2'b01: begin m_inner = d[3:0]; if (!m_mir[1]) m_mir = {1'b0, d[4]}; end
            2'b10: begin m_mir = d[1:0]; m_prg = d[3:2]; m_size = d[5:4]; end
            default: m_outer = d[5:0];
         endcase
      end
      if (push) begin
         q_exp.push_back(exp_vec());
         q_tag.push_back(tag);
      end
   endtask

   task automatic wr(input logic [3:0] hi, input logic [7:0] d, input string tag);
      op(1'b0, hi, d, ppu_a11, ppu_a10, tag, 1'b1);
   endtask

   task automatic ppu(input logic a11, input logic a10, input string tag);
      op(1'b1, 4'h0, 8'h00, a11, a10, tag, 1'b1);
   endtask

   // monitor: compare one expected item per rising edge
   initial begin
      forever begin
         @(posedge m2);
         if (q_exp.size() > 0) begin
            logic [18:0] e, a;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            a = {chr_bank, ciram_a10, mirror_mode, prg_mode, outer_size, inner_bank, outer_bank};
            n_chk++;
            if (a !== e) begin
               n_bad++;
               $display("FAIL %s actual=%05h expected=%05h", t, a, e);
            end
         end
      end
   end

   initial begin
      int cyc = 0;
      forever begin
         @(posedge m2);
         cyc++;
         if (cyc > 5000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<5000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      // preload: no reset exists (R11)
      op(1'b0, 4'h5, 8'h81, 0, 0, "pre", 1'b0);
      op(1'b0, 4'h8, 8'h3F, 0, 0, "pre", 1'b0);
      op(1'b0, 4'h5, 8'h80, 0, 0, "pre", 1'b0);
      op(1'b0, 4'h8, 8'h02, 0, 0, "pre", 1'b0);
      op(1'b0, 4'h5, 8'h00, 0, 0, "pre", 1'b0);
      op(1'b0, 4'h8, 8'h03, 0, 0, "pre", 1'b0);
      op(1'b0, 4'h5, 8'h01, 0, 0, "pre", 1'b0);
      op(1'b0, 4'h8, 8'h0F, 0, 0, "pre", 1'b0);
      // R11: state held over idle cycles
      for (int k = 0; k < 4; k++) ppu(0, 0, "R11 idle hold");
      // R7 vertical
      ppu(0, 1, "R7 vertical a10=1");
      ppu(1, 0, "R7 vertical a11=1");
      // R5 / R7 horizontal
      wr(4'h5, 8'h80, "R1 select mode");
      wr(4'h8, 8'h03, "R5 mode horizontal");
      ppu(1, 0, "R7 horizontal a11=1");
      ppu(0, 1, "R7 horizontal a10=1");
      // R1 high page edge, extra data bits ignored; R9 D4 blocked
      wr(4'h5, 8'h7E, "R1 select chr via 7E");
      wr(4'hC, 8'h12, "R3 R9 chr=2 d4 blocked");
      wr(4'h5, 8'h01, "R1 select inner");
      wr(4'h8, 8'h15, "R4 R9 inner=5 d4 blocked");
      // R5 one-screen high
      wr(4'h5, 8'h80, "R1 select mode");
      wr(4'hF, 8'h35, "R2 R5 mode 35");
      ppu(1, 1, "R7 one-screen high");
      // R8 D4 copies
      wr(4'h5, 8'h01, "R1 select inner");
      wr(4'h8, 8'h00, "R8 inner=0 mirror->0");
      ppu(1, 1, "R7 one-screen low");
      wr(4'h5, 8'h00, "R1 select chr");
      wr(4'h8, 8'h11, "R8 chr=1 mirror->1");
      // R6 outer width
      wr(4'h5, 8'hFF, "R1 select outer via FF");
      wr(4'h9, 8'hAB, "R6 outer keeps low bits");
      // R10 ignored cycles
      op(1'b1, 4'h8, 8'h00, 1, 1, "R10 read ignored", 1'b1);
      wr(4'h6, 8'h00, "R10 6xxx ignored");
      wr(4'h4, 8'h00, "R10 4xxx not selector");
      wr(4'h7, 8'h80, "R10 7xxx not selector");
      wr(4'h8, 8'h05, "R2 R10 still outer");
      // R2 mode via top page, vertical again
      wr(4'h5, 8'h80, "R1 select mode");
      wr(4'hF, 8'h0E, "R2 R5 mode 0E");
      wr(4'h5, 8'h00, "R1 select chr");
      wr(4'h8, 8'h10, "R9 vertical d4 blocked");
      ppu(0, 1, "R7 vertical after");
      op(1'b1, 4'h0, 8'h00, 0, 0, "R11 final idle", 1'b1);
      @(posedge m2);
      @(posedge m2);
      #2;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule